// File: doc/BRIEF.md
# Audio Word Unpacker FIFO

This block sits between a register-mapped sample port and a serial audio frame encoder. A bus master writes 32-bit words to the data address. The block turns each word into one or two right-aligned audio samples and tags each sample with a channel. It queues the tagged samples in a small FIFO, and the encoder drains that FIFO through a valid/ready handshake.

How a word is cut up depends on a mode register. The mode register sets the sample width in bytes, the count of valid bits, the byte order, the justification, mono or two-channel operation, and how channels are assigned. Channels can be assigned by address, by alternation, or by packing two halves into one word. A write-only control address gives a full soft reset and a FIFO-only flush. A status vector reports the FIFO fill level, a chunk-space indication, per-channel readiness and a sticky overrun flag.

The single write port has four addresses:

| Address | Use |
|---|---|
| 0 | Control |
| 1 | Mode |
| 2 | Data, channel 1 in indexed mode |
| 3 | Data, channel 2 in indexed mode |

In the other access modes, addresses 2 and 3 behave the same.

Top module: `pcm_word_unpacker`

## Requirements
- R1: After reset the mode readback is 0, out_valid is 0 and status equals 0x010B.
- R2: Mode field layout and write rules.
  - The mode register keeps these fields: enable at bit 0, dual at bit 1, big-endian at bit 2, MSB-justify at bit 3, access mode at bits 5:4, valid bits at 13:8, chunk at 19:16, and bytes-minus-one at 29:28.
  - All other bits read back as 0.
  - While the stored enable bit is 1, a mode write changes only bit 0.
- R3: Every data write that fits is queued in order. out_valid is 1 only while enable is 1 and the FIFO holds a sample. A sample leaves the FIFO on a cycle where out_valid and out_ready are both 1.
- R4: The byte field is the low 8·(bytes) bits of the word. The effective width is the valid-bit count, or the full field width when that count is 0 or larger than the field. With LSB justification the sample is the low effective-width bits of the field, and all other output bits are 0.
- R5: With MSB justification the sample is the top effective-width bits of the byte field, shifted down to bit 0, and all other output bits are 0.
- R6: In big-endian mode the bytes inside the byte field are reversed before justification.
- R7: In toggle access (code 1; code 3 acts the same) with dual set, accepted writes alternate channel tags 0, 1, 0, and so on. The sequence restarts at 0 after a soft reset or a FIFO clear. With dual clear, every tag is 0.
- R8: In indexed access (code 0) with dual set, a write to address 2 is tagged 0 and a write to address 3 is tagged 1.
- R9: Interleaved access (code 2), two samples per word.
  - One word yields two samples, queued in this order: the low 16 bits tagged 0, then the high 16 bits tagged 1.
  - Both are zero-extended. Byte order and justification are not applied.
  - The word is accepted only when at least two entries are free.
- R10: A data write that does not fit is dropped whole and sets the overrun flag (status bit 5). Only a soft reset clears that flag.
- R11: Status bit 0 is 1 when the FIFO is not full. Bit 1 is 1 when it is empty. Bit 2 is 1 when it is full. Bit 3 is 1 when the free entries are at least the chunk field, with a chunk field of 0 counting as 1.
- R12: Status bits 8 and 9 report readiness for channel 0 and channel 1, by access mode:

  | Access mode and channel setting | Bit 8 | Bit 9 |
  |---|---|---|
  | Interleaved | 1 when two or more entries are free | same as bit 8 |
  | Mono, non-interleaved | 1 when not full | 0 |
  | Dual, indexed | 1 when not full | 1 when not full |
  | Dual, toggle | 1 when not full and channel 0 is due next | 1 when not full and channel 1 is due next |
- R13: A control write with bit 1 set empties the FIFO and restarts the toggle sequence, but keeps the mode and the overrun flag. A control write with bit 0 set does all of that and also clears the mode and the overrun flag. Setting both bits acts as a soft reset.
- R14: When a write and a pop fall in the same cycle, whether the write fits is judged on the occupancy before that edge. A single-sample write plus a pop leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 mode, 2/3 data |
| wr_data | input | 32 | Write data |
| mode_rd | output | 32 | Current mode register contents |
| status | output | 16 | Status flags |
| out_valid | output | 1 | A sample is offered to the encoder |
| out_ready | input | 1 | The encoder takes the offered sample |
| out_sample | output | 32 | Right-aligned sample |
| out_chan | output | 1 | Channel tag of the sample |

## Verification
A data write from the bus and a pop by the encoder can land on the same clock edge, and they interact only through the occupancy count. The bench provokes this in two situations.

In the first, a single-sample write arrives together with a pop while one sample is queued. The bench judges it by the next head value and an unchanged empty/full status. In the second, the FIFO is full. The bench checks that the write is dropped even though a slot frees on that edge: the overrun flag is set, the fill level falls to seven, and the next queued sample comes forward.

// File: rtl/pcm_unp_pkg.sv
package pcm_unp_pkg;

    localparam int WORD_W = 32;

    // register select codes
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_MODE   = 2'd1;

    // bits the mode register keeps; all others read as zero
    localparam logic [31:0] MODE_KEEP_MASK = 32'h300F_3F3F;

    typedef enum logic [1:0] {
        ACC_INDEXED    = 2'd0,
        ACC_TOGGLE     = 2'd1,
        ACC_INTERLEAVE = 2'd2,
        ACC_RSVD       = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic        tx_on;
        logic        dual;
        logic        big_end;
        logic        msb_just;
        acc_mode_e   acc;
        logic [5:0]  vbits;
        logic [3:0]  chunk;
        logic [1:0]  bytes_m1;
    } mode_t;

    typedef struct packed {
        logic              chan;
        logic [WORD_W-1:0] data;
    } tagged_smp_t;

    function automatic mode_t unpack_mode(input logic [31:0] w);
        mode_t m;
        m.tx_on    = w[0];
        m.dual     = w[1];
        m.big_end  = w[2];
        m.msb_just = w[3];
        m.acc      = acc_mode_e'(w[5:4]);
        m.vbits    = w[13:8];
        m.chunk    = w[19:16];
        m.bytes_m1 = w[29:28];
        return m;
    endfunction

endpackage

// File: rtl/pcm_unp_modereg.sv
module pcm_unp_modereg
    import pcm_unp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] mode_word,
    output logic        soft_rst,
    output logic        fifo_clr
);

    typedef struct packed {
        logic [31:0] mode;
    } mreg_t;

    mreg_t st_d, st_q;
    logic  ctrl_wr, mode_wr;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        mode_wr  = wr_en && (wr_addr == ADDR_MODE);
        soft_rst = ctrl_wr && wr_data[0];
        fifo_clr = ctrl_wr && wr_data[1];

        st_d = st_q;
        if (soft_rst) begin
            st_d.mode = '0;
        end else if (mode_wr) begin
            if (st_q.mode[0]) begin
                // running: only the enable bit may move
                st_d.mode = {st_q.mode[31:1], wr_data[0]};
            end else begin
                st_d.mode = wr_data & MODE_KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_word = st_q.mode;

    // R2: configuration frozen while transmitting
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[0] && !soft_rst) |=> $stable(st_q.mode[31:1]));

endmodule

// File: rtl/pcm_unp_slicer.sv
module pcm_unp_slicer
    import pcm_unp_pkg::*;
(
    input  logic              data_wr,
    input  logic              addr_lsb,
    input  logic [WORD_W-1:0] word,
    input  logic              dual,
    input  logic              big_end,
    input  logic              msb_just,
    input  acc_mode_e         acc,
    input  logic [5:0]        vbits,
    input  logic [1:0]        bytes_m1,
    input  logic              next_chan,
    output tagged_smp_t       smp0,
    output tagged_smp_t       smp1,
    output logic [1:0]        need
);

    localparam int NB   = WORD_W / 8;
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] field, shifted, keep_mask;
    logic [5:0]        field_w, eff_w;
    logic              inter;

    always_comb begin
        // gather the byte field, reversing byte order when asked
        field = '0;
        for (int b = 0; b < NB; b++) begin
            if (b <= int'(bytes_m1)) begin
                if (big_end) field[8*b +: 8] = word[8*(int'(bytes_m1) - b) +: 8];
                else         field[8*b +: 8] = word[8*b +: 8];
            end
        end

        field_w = {1'b0, bytes_m1, 3'b000} + 6'd8;
        eff_w   = ((vbits == 6'd0) || (vbits > field_w)) ? field_w : vbits;

        shifted   = msb_just ? (field >> (field_w - eff_w)) : field;
        keep_mask = {WORD_W{1'b1}} >> (6'(WORD_W) - eff_w);

        inter = (acc == ACC_INTERLEAVE);
        smp0  = '0;
        smp1  = '0;
        if (inter) begin
            smp0.chan = 1'b0;
            smp0.data = {{HALF{1'b0}}, word[HALF-1:0]};
            smp1.chan = 1'b1;
            smp1.data = {{HALF{1'b0}}, word[WORD_W-1:HALF]};
        end else begin
            smp0.data = shifted & keep_mask;
            if (!dual)                   smp0.chan = 1'b0;
            else if (acc == ACC_INDEXED) smp0.chan = addr_lsb;
            else                         smp0.chan = next_chan;
        end

        if (!data_wr)   need = 2'd0;
        else if (inter) need = 2'd2;
        else            need = 2'd1;
    end

endmodule

// File: rtl/pcm_unp_fifo.sv
module pcm_unp_fifo
    import pcm_unp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic [1:0]                   push_n,
    input  tagged_smp_t                  in0,
    input  tagged_smp_t                  in1,
    input  logic                         pop,
    output tagged_smp_t                  head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        tagged_smp_t [DEPTH-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     popped;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        popped = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (popped) st_d.rp = inc(st_q.rp);
            if (push_n != 2'd0) st_d.mem[st_q.wp] = in0;
            if (push_n == 2'd2) st_d.mem[inc(st_q.wp)] = in1;
            case (push_n)
                2'd1:    st_d.wp = inc(st_q.wp);
                2'd2:    st_d.wp = inc(inc(st_q.wp));
                default: st_d.wp = st_q.wp;
            endcase
            st_d.cnt = st_q.cnt + CW'(push_n) - CW'(popped);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    // R10: the producer never offers more than the free space
    p_push_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (32'(push_n) + 32'(st_q.cnt) <= 32'(DEPTH)));

    // R11: occupancy stays within the storage
    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.cnt) <= 32'(DEPTH));

    // R13: a flush leaves the queue empty
    p_clear_empties_r13: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

    // R14: one in, one out keeps the level
    p_pushpop_balance_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && push_n == 2'd1 && pop && st_q.cnt != '0) |=> $stable(st_q.cnt));

endmodule

// File: rtl/pcm_word_unpacker.sv
module pcm_word_unpacker
    import pcm_unp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] mode_rd,
    output logic [15:0] status,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_sample,
    output logic        out_chan
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic next_ch;
        logic ovr;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic [31:0] mode_word;
    mode_t       mode;
    logic        soft_rst, fifo_clr, data_wr, accept, drop, toggle_mode;
    logic [1:0]  need, push_n;
    logic [CW-1:0] count, free;
    logic [4:0]  chunk_eff;
    tagged_smp_t smp0, smp1, head;
    logic        full, empty, two_free;

    pcm_unp_modereg u_modereg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_word (mode_word),
        .soft_rst  (soft_rst),
        .fifo_clr  (fifo_clr)
    );

    assign mode    = unpack_mode(mode_word);
    assign data_wr = wr_en && wr_addr[1];

    pcm_unp_slicer u_slicer (
        .data_wr   (data_wr),
        .addr_lsb  (wr_addr[0]),
        .word      (wr_data),
        .dual      (mode.dual),
        .big_end   (mode.big_end),
        .msb_just  (mode.msb_just),
        .acc       (mode.acc),
        .vbits     (mode.vbits),
        .bytes_m1  (mode.bytes_m1),
        .next_chan (st_q.next_ch),
        .smp0      (smp0),
        .smp1      (smp1),
        .need      (need)
    );

    always_comb begin
        free        = CW'(FIFO_DEPTH) - count;
        full        = (count == CW'(FIFO_DEPTH));
        empty       = (count == '0);
        two_free    = (32'(free) >= 32'd2);
        accept      = data_wr && (32'(need) <= 32'(free));
        drop        = data_wr && !accept;
        push_n      = accept ? need : 2'd0;
        toggle_mode = (mode.acc == ACC_TOGGLE) || (mode.acc == ACC_RSVD);
        chunk_eff   = (mode.chunk == 4'd0) ? 5'd1 : {1'b0, mode.chunk};

        st_d = st_q;
        if (soft_rst) begin
            st_d = '0;
        end else if (fifo_clr) begin
            st_d.next_ch = 1'b0;
        end else begin
            if (drop) st_d.ovr = 1'b1;
            if (accept && need == 2'd1 && mode.dual && toggle_mode)
                st_d.next_ch = !st_q.next_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pcm_unp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst || fifo_clr),
        .push_n (push_n),
        .in0    (smp0),
        .in1    (smp1),
        .pop    (out_valid && out_ready),
        .head   (head),
        .count  (count)
    );

    always_comb begin
        status    = '0;
        status[0] = !full;
        status[1] = empty;
        status[2] = full;
        status[3] = 32'(free) >= 32'(chunk_eff);
        status[5] = st_q.ovr;
        if (mode.acc == ACC_INTERLEAVE) begin
            status[8] = two_free;
            status[9] = two_free;
        end else if (!mode.dual) begin
            status[8] = !full;
        end else if (mode.acc == ACC_INDEXED) begin
            status[8] = !full;
            status[9] = !full;
        end else begin
            status[8] = !full && !st_q.next_ch;
            status[9] = !full &&  st_q.next_ch;
        end
    end

    assign mode_rd    = mode_word;
    assign out_valid  = mode.tx_on && !empty;
    assign out_sample = head.data;
    assign out_chan   = head.chan;

    // R10: overrun persists until a soft reset
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !soft_rst) |=> st_q.ovr);

    // R7: each accepted toggle write advances the channel
    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && need == 2'd1 && mode.dual && toggle_mode && !soft_rst && !fifo_clr)
        |=> (st_q.next_ch != $past(st_q.next_ch)));

endmodule

// File: tb/pcm_word_unpacker_bench.sv
module pcm_word_unpacker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] word;
        logic [31:0] exp;
    } vec_t;

    // single-sample unpack cases, mono toggle mode, tag 0 expected
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0810, 32'hDEAD_BEEF, 32'h0000_00EF},  // R4 1 byte
        '{32'h1000_1010, 32'h1234_ABCD, 32'h0000_ABCD},  // R4 2 bytes
        '{32'h2000_1410, 32'h1234_5678, 32'h0004_5678},  // R4 20 of 24
        '{32'h2000_1418, 32'h00AB_CDEF, 32'h000A_BCDE},  // R5 msb 20 of 24
        '{32'h2000_1814, 32'h0011_2233, 32'h0033_2211},  // R6 3-byte swap
        '{32'h3000_2014, 32'h1122_3344, 32'h4433_2211},  // R6 4-byte swap
        '{32'h1000_101C, 32'hFFFF_A1B2, 32'h0000_B2A1},  // R6 R5 16 bits
        '{32'h3000_1818, 32'h89AB_CDEF, 32'h0089_ABCD},  // R5 24 of 32
        '{32'h3000_1210, 32'hFFFF_FFFF, 32'h0003_FFFF},  // R4 18 of 32
        '{32'h0000_0010, 32'h1234_567F, 32'h0000_007F},  // R4 zero count
        '{32'h1000_1810, 32'h00FF_8001, 32'h0000_8001},  // R4 clamp
        '{32'h2000_121C, 32'h00C0_FFEE, 32'h0003_BBFF}   // R5 R6 combined
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        out_ready = 1'b0;
    logic [31:0] mode_rd, out_sample;
    logic [15:0] status;
    logic        out_valid, out_chan;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_word_unpacker u_pcm_word_unpacker (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode_rd    (mode_rd),
        .status     (status),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .out_chan   (out_chan)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_pop(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; out_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; out_ready = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] d, input logic c);
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, out_sample, d);
        chk(req, {31'd0, out_chan}, {31'd0, c});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {16'd0, status}, 32'h0000_010B);
        chk("R1 mode", mode_rd, 32'd0);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);

        // R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 32'd1);
            wr(2'd1, VECS[i].mode);
            chk("R2 mode readback", mode_rd, VECS[i].mode);
            wr(2'd2, VECS[i].word);
            chk("R3 held while disabled", {31'd0, out_valid}, 32'd0);
            wr(2'd1, VECS[i].mode | 32'd1);
            pop_chk("R4 R5 R6 unpack", VECS[i].exp, 1'b0);
            chk("R3 drained", {31'd0, out_valid}, 32'd0);
        end

        // R2 masking and freeze, R13 flush keeps mode
        wr(2'd0, 32'd1);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R2 mask", mode_rd, 32'h300F_3F3F);
        wr(2'd1, 32'h0000_0000);
        chk("R2 frozen", mode_rd, 32'h300F_3F3E);
        wr(2'd1, 32'h1234_0011);
        chk("R2 rewrite", mode_rd, 32'h1004_0011);
        wr(2'd0, 32'd2);
        chk("R13 flush keeps mode", mode_rd, 32'h1004_0011);
        wr(2'd0, 32'd3);
        chk("R13 soft reset mode", mode_rd, 32'd0);

        // R7 toggle, R12 per-channel readiness, R13 restart
        wr(2'd1, 32'h1000_1012);
        wr(2'd2, 32'h0000_A001);
        wr(2'd2, 32'h0000_A002);
        wr(2'd2, 32'h0000_A003);
        chk("R12 toggle next ch1", {30'd0, status[9:8]}, 32'd2);
        wr(2'd0, 32'd2);
        chk("R13 flush empties", {31'd0, status[1]}, 32'd1);
        chk("R7 R12 restart ch0", {30'd0, status[9:8]}, 32'd1);
        wr(2'd2, 32'h0000_D00D);
        wr(2'd2, 32'h0000_E00E);
        wr(2'd1, 32'h1000_1013);
        pop_chk("R7 first tag", 32'h0000_D00D, 1'b0);
        pop_chk("R7 second tag", 32'h0000_E00E, 1'b1);

        // R8 indexed
        wr(2'd0, 32'd1);
        wr(2'd1, 32'h1000_1002);
        wr(2'd3, 32'h0000_AAAA);
        wr(2'd2, 32'h0000_BBBB);
        chk("R12 indexed both", {30'd0, status[9:8]}, 32'd3);
        wr(2'd1, 32'h1000_1003);
        pop_chk("R8 addr3", 32'h0000_AAAA, 1'b1);
        pop_chk("R8 addr2", 32'h0000_BBBB, 1'b0);

        // R9 interleaved
        wr(2'd0, 32'd1);
        wr(2'd1, 32'h0000_0020);
        wr(2'd2, 32'hBEEF_1234);
        chk("R9 R11 R12 status", {16'd0, status}, 32'h0000_0309);
        wr(2'd1, 32'h0000_0021);
        pop_chk("R9 low half", 32'h0000_1234, 1'b0);
        pop_chk("R9 high half", 32'h0000_BEEF, 1'b1);

        // R9 R10 R11 overrun and fill flags
        wr(2'd0, 32'd1);
        wr(2'd1, 32'h0000_0020);
        for (int k = 0; k < 3; k++) wr(2'd2, 32'h0000_0000);
        wr(2'd1, 32'h0000_0010);
        wr(2'd2, 32'h0000_0000);
        wr(2'd1, 32'h0000_0020);
        wr(2'd2, 32'h5555_5555);
        chk("R9 R10 pair dropped", {16'd0, status}, 32'h0000_0029);
        wr(2'd1, 32'h0000_0010);
        wr(2'd2, 32'h0000_0000);
        chk("R10 R11 full", {16'd0, status}, 32'h0000_0024);
        wr(2'd2, 32'h0000_0000);
        chk("R10 still full", {16'd0, status}, 32'h0000_0024);
        wr(2'd0, 32'd2);
        chk("R10 R13 flush keeps overrun", {16'd0, status}, 32'h0000_012B);
        wr(2'd0, 32'd1);
        chk("R10 R13 soft reset", {16'd0, status}, 32'h0000_010B);

        // R11 chunk space
        wr(2'd1, 32'h0004_0010);
        for (int k = 0; k < 4; k++) wr(2'd2, 32'h0000_0000);
        chk("R11 chunk met", {16'd0, status}, 32'h0000_0109);
        wr(2'd2, 32'h0000_0000);
        chk("R11 chunk short", {16'd0, status}, 32'h0000_0101);

        // R14 write and pop in one cycle
        wr(2'd0, 32'd1);
        wr(2'd1, 32'h1000_1010);
        wr(2'd1, 32'h1000_1011);
        wr(2'd2, 32'h0000_1111);
        wr_pop(2'd2, 32'h0000_2222);
        chk("R14 head after swap", out_sample, 32'h0000_2222);
        chk("R14 level", {16'd0, status}, 32'h0000_0109);
        pop_chk("R14 drain", 32'h0000_2222, 1'b0);
        for (int k = 0; k < 8; k++) wr(2'd2, 32'h0000_0030 + 32'(k));
        chk("R11 full enabled", {16'd0, status}, 32'h0000_0004);
        wr_pop(2'd2, 32'h0000_DEAD);
        chk("R14 R10 drop on full", {16'd0, status}, 32'h0000_0129);
        chk("R14 R3 next head", out_sample, 32'h0000_0031);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule